// File: doc/BRIEF.md
# Multi-Phase Power Sequencer

This block walks a step counter up and down a numbered range to switch a set of supply-enable outputs in a fixed order. Three programmable pointers (system end, power end, maximum) split the range into three phases. Each phase opens only when its own enable is present:

- a system enable, from a pin or a preset configuration bit;
- a power enable, from a pin, a register bit or a preset configuration bit;
- a register-written third-phase enable.

The counter moves one step per dwell period. Each supply output is tied to one step and is on whenever the counter stands at or above that step.

On the way down, the stopping point depends on what was removed:

- Dropping power enable returns the walk to the system-end step.
- Dropping system enable returns it to step 0.
- A standby request stops it at a partial-down pointer. The next power-up then climbs from there.
- A watchdog timeout pulse puts the counter on step 0 in a single cycle. It holds it there until system enable has been removed once.

The block drives the current step, the enable vector, the walk direction and an ACTIVE flag.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, `cur_step` is 0, `reg_en` is all zero, `walk_dir` is 2'b00 and `active` is 0.
- R2: With system enable absent (`sys_en_pin` and `cfg_sys_preset` both 0), the step stays at or returns to 0. With system enable present (pin or preset) and power enable absent, the step settles at t1 = min(`sys_end_ptr`, `max_ptr`).
- R3: With system enable present and power enable present (any of `pwr_en_pin`, `pwr_en_reg`, `cfg_pwr_preset`), the step settles at t2 = max(t1, min(`pwr_end_ptr`, `max_ptr`)).
- R4: With system and power enable present and `ph3_en_reg` set, the step settles at t3 = max(t2, `max_ptr`). No step above t3 is visited.
- R5: `active` is 1 exactly when system enable and power enable are present, `standby_req` is 0, no watchdog lock is held, and `cur_step` >= t2.
- R6: Power-down walks the steps in reverse, one at a time. Removing power enable from a higher step stops the walk at t1. Removing system enable continues the walk to step 0.
- R7: While `standby_req` is 1, the step settles at the partial-down step. That step is `part_down_ptr` when it is less than `sys_end_ptr`, and 0 otherwise. After `standby_req` clears, the step climbs upward from that step.
- R8: A one-cycle `wdog_expire` puts `cur_step` at 0 and clears all of `reg_en` at the next clock edge. The step then stays 0 while system enable remains present. Once system enable has been absent for at least one cycle, normal stepping resumes.
- R9: Once the goal differs from the current step, the step changes by exactly one every `dwell_cycles`+1 clock cycles.
- R10: `reg_en[i]` is 1 exactly when `reg_auto[i]` is 1, the step field `reg_step_map[i*5 +: 5]` is nonzero, and that field is <= `cur_step`.
- R11: `walk_dir` encodes 2'b01 while the step is below its goal and 2'b10 while it is above its goal. It encodes 2'b00 when the two are equal or while the watchdog lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_en_pin | input | 1 | System enable pin |
| pwr_en_pin | input | 1 | Power enable pin |
| pwr_en_reg | input | 1 | Power enable register bit |
| ph3_en_reg | input | 1 | Third-phase enable register bit |
| standby_req | input | 1 | Partial power-down request |
| wdog_expire | input | 1 | Watchdog timeout pulse |
| cfg_sys_preset | input | 1 | System enable preset in configuration |
| cfg_pwr_preset | input | 1 | Power enable preset in configuration |
| sys_end_ptr | input | 5 | Last step of phase 1 |
| pwr_end_ptr | input | 5 | Last step of phase 2 |
| max_ptr | input | 5 | Last step of phase 3, upper clamp |
| part_down_ptr | input | 5 | Standby stopping step |
| dwell_cycles | input | DWELL_W | Extra cycles spent on each step before moving |
| reg_step_map | input | NUM_REG*5 | Assigned step of each supply, 5 bits each |
| reg_auto | input | NUM_REG | Sequencer control allowed, per supply |
| cur_step | output | 5 | Current step |
| reg_en | output | NUM_REG | Supply enables |
| walk_dir | output | 2 | 00 idle, 01 up, 10 down |
| active | output | 1 | ACTIVE mode flag |

## Verification
The bench builds the block with a 5-bit step, eight supplies and a 4-bit dwell field, and runs it with a dwell of two. With these values every one of the 32 steps can be reached within about a hundred cycles. This makes it affordable to sweep all sixteen combinations of system enable, power enable, third-phase enable and standby. The sweep is run under three pointer sets: an ordinary one, one whose maximum lies below the system end and whose partial-down pointer is illegal, and one with a maximum far above power end. The supply map includes a step-0 entry, a supply with automatic control cleared and two supplies sharing one step, so each masking rule shows up at the enable outputs.

// File: rtl/pwr_seq_pkg.sv
// Package: shared types for the power sequencer.
// Assumes: a 2-bit direction code is visible at the top ports.
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        DIR_IDLE = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } walk_dir_e;
endpackage

// File: rtl/pwr_seq_goal.sv
// Module: pwr_seq_goal
// Works out the step the walker is heading for, from the enables and pointers.
// Also derives the ACTIVE flag. Assumes pointers may be mis-ordered: they are
// clamped so phase ends never decrease and never pass the maximum pointer.
module pwr_seq_goal #(
    parameter int STEP_W = 5
) (
    input  logic              sys_on,
    input  logic              pwr_on,
    input  logic              ph3_on,
    input  logic              standby,
    input  logic              wd_lock,
    input  logic [STEP_W-1:0] sys_end_ptr,
    input  logic [STEP_W-1:0] pwr_end_ptr,
    input  logic [STEP_W-1:0] max_ptr,
    input  logic [STEP_W-1:0] part_down_ptr,
    input  logic [STEP_W-1:0] cur_step,
    output logic [STEP_W-1:0] goal,
    output logic              active
);
    logic [STEP_W-1:0] end1, clip2, end2, end3, stby_stop;

    // Clamp the three phase ends and the standby stop.
    always_comb begin
        end1      = (sys_end_ptr < max_ptr) ? sys_end_ptr : max_ptr;
        clip2     = (pwr_end_ptr < max_ptr) ? pwr_end_ptr : max_ptr;
        end2      = (clip2 > end1) ? clip2 : end1;
        end3      = (max_ptr > end2) ? max_ptr : end2;
        stby_stop = (part_down_ptr < sys_end_ptr) ? part_down_ptr : '0;
    end

    // Pick the target step in priority order: lock, standby, then the phase enables.
    always_comb begin
        if (wd_lock)      goal = '0;
        else if (standby) goal = stby_stop;
        else if (!sys_on) goal = '0;
        else if (!pwr_on) goal = end1;
        else if (!ph3_on) goal = end2;
        else              goal = end3;
    end

    // ACTIVE holds while both enables stand and the walker sits at or above the phase-2 end.
    always_comb begin
        active = sys_on && pwr_on && !standby && !wd_lock && (cur_step >= end2);
    end
endmodule

// File: rtl/pwr_seq_dwell.sv
// Module: pwr_seq_dwell
// Dwell timer: issues one move tick after dwell_cycles+1 cycles of pending motion.
// Assumes the goal may change at any cycle; the count restarts whenever motion stops.
module pwr_seq_dwell #(
    parameter int STEP_W  = 5,
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STEP_W-1:0]  cur_step,
    input  logic [STEP_W-1:0]  goal,
    input  logic [DWELL_W-1:0] dwell_cycles,
    output logic               tick
);
    logic               pending;
    logic [DWELL_W-1:0] cnt;

    // Motion is pending while the step differs from its goal.
    always_comb begin
        pending = (cur_step != goal);
        tick    = pending && (cnt == dwell_cycles);
    end

    // Count the dwell; restart on every move and whenever nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!pending || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R9
    // dwell_limit_chk: the counter never runs past the programmed dwell while motion is pending
    dwell_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending && $stable(dwell_cycles) |-> cnt <= dwell_cycles);
endmodule

// File: rtl/pwr_seq_stepper.sv
// Module: pwr_seq_stepper
// Holds the step counter and the watchdog lock, and moves one step per tick.
// Assumes tick is raised only while step and goal differ. A watchdog pulse wins over any move.
module pwr_seq_stepper #(
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [STEP_W-1:0] goal,
    input  logic              wdog,
    input  logic              sys_on,
    output logic [STEP_W-1:0] cur_step,
    output logic              wd_lock,
    output logic [1:0]        dir_code
);
    import pwr_seq_pkg::*;

    walk_dir_e dir;

    // Step register and lock: watchdog snaps to 0, else one step toward the goal per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_step <= '0;
            wd_lock  <= 1'b0;
        end else if (wdog) begin
            cur_step <= '0;
            wd_lock  <= 1'b1;
        end else begin
            if (wd_lock && !sys_on) wd_lock <= 1'b0;
            if (tick && !wd_lock)
                cur_step <= (goal > cur_step) ? cur_step + 1'b1 : cur_step - 1'b1;
        end
    end

    // Direction of the pending walk.
    always_comb begin
        if (wd_lock)              dir = DIR_IDLE;
        else if (goal > cur_step) dir = DIR_UP;
        else if (goal < cur_step) dir = DIR_DOWN;
        else                      dir = DIR_IDLE;
        dir_code = dir;
    end

    // R6
    // step_delta_chk: outside a watchdog event the step moves by at most one
    step_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wdog) && (cur_step != $past(cur_step)) |->
            (cur_step == $past(cur_step) + 1'b1) || (cur_step == $past(cur_step) - 1'b1));

    // R8
    // wdog_zero_chk: a watchdog pulse lands the step on 0 at the next edge
    wdog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog |=> (cur_step == '0));

    // R8
    // wd_hold_chk: the step cannot leave 0 while the lock stands
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_lock |-> (cur_step == '0));

    // R9
    // dwell_gate_chk: every ordinary step change was granted by the dwell timer
    dwell_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wdog) && (cur_step != $past(cur_step)) |-> $past(tick));
endmodule

// File: rtl/pwr_seq_regmap.sv
// Module: pwr_seq_regmap
// Maps the step counter to supply enables: a supply is on once the walker stands at
// or above its assigned step. A step-0 assignment or a cleared auto bit keeps it off.
module pwr_seq_regmap #(
    parameter int STEP_W  = 5,
    parameter int NUM_REG = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [STEP_W-1:0]         cur_step,
    input  logic [NUM_REG*STEP_W-1:0] step_map,
    input  logic [NUM_REG-1:0]        auto_en,
    output logic [NUM_REG-1:0]        en
);
    for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_sup
        logic [STEP_W-1:0] slot;

        // Decode this supply's enable from its slot and the current step.
        always_comb begin
            slot   = step_map[gi*STEP_W +: STEP_W];
            en[gi] = auto_en[gi] && (slot != '0) && (slot <= cur_step);
        end

        // R10
        // rise_on_up_chk: with a fixed configuration a supply only turns on while climbing
        rise_on_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en[gi]) && $stable(slot) && $stable(auto_en[gi]) |-> cur_step > $past(cur_step));

        // R10
        // fall_on_down_chk: with a fixed configuration a supply only turns off while descending
        fall_on_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en[gi]) && $stable(slot) && $stable(auto_en[gi]) |-> cur_step < $past(cur_step));
    end
endmodule

// File: rtl/pwr_seq_top.sv
// Module: pwr_seq_top
// Three-phase power sequencer: combines the enable sources, computes the goal step,
// paces the walk with a dwell timer and decodes supply enables from the step.
// Assumes all inputs are synchronous to clk; the watchdog input is a single-cycle pulse.
module pwr_seq_top #(
    parameter int STEP_W  = 5,
    parameter int NUM_REG = 8,
    parameter int DWELL_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sys_en_pin,
    input  logic                      pwr_en_pin,
    input  logic                      pwr_en_reg,
    input  logic                      ph3_en_reg,
    input  logic                      standby_req,
    input  logic                      wdog_expire,
    input  logic                      cfg_sys_preset,
    input  logic                      cfg_pwr_preset,
    input  logic [STEP_W-1:0]         sys_end_ptr,
    input  logic [STEP_W-1:0]         pwr_end_ptr,
    input  logic [STEP_W-1:0]         max_ptr,
    input  logic [STEP_W-1:0]         part_down_ptr,
    input  logic [DWELL_W-1:0]        dwell_cycles,
    input  logic [NUM_REG*STEP_W-1:0] reg_step_map,
    input  logic [NUM_REG-1:0]        reg_auto,
    output logic [STEP_W-1:0]         cur_step,
    output logic [NUM_REG-1:0]        reg_en,
    output logic [1:0]                walk_dir,
    output logic                      active
);
    logic              sys_on, pwr_on;
    logic              wd_lock, tick;
    logic [STEP_W-1:0] goal;

    // Merge the enable sources: pins, register bits and configuration presets.
    always_comb begin
        sys_on = sys_en_pin || cfg_sys_preset;
        pwr_on = pwr_en_pin || pwr_en_reg || cfg_pwr_preset;
    end

    pwr_seq_goal #(.STEP_W(STEP_W)) u_goal (
        .sys_on       (sys_on),
        .pwr_on       (pwr_on),
        .ph3_on       (ph3_en_reg),
        .standby      (standby_req),
        .wd_lock      (wd_lock),
        .sys_end_ptr  (sys_end_ptr),
        .pwr_end_ptr  (pwr_end_ptr),
        .max_ptr      (max_ptr),
        .part_down_ptr(part_down_ptr),
        .cur_step     (cur_step),
        .goal         (goal),
        .active       (active)
    );

    pwr_seq_dwell #(.STEP_W(STEP_W), .DWELL_W(DWELL_W)) u_dwell (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_step    (cur_step),
        .goal        (goal),
        .dwell_cycles(dwell_cycles),
        .tick        (tick)
    );

    pwr_seq_stepper #(.STEP_W(STEP_W)) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .goal    (goal),
        .wdog    (wdog_expire),
        .sys_on  (sys_on),
        .cur_step(cur_step),
        .wd_lock (wd_lock),
        .dir_code(walk_dir)
    );

    pwr_seq_regmap #(.STEP_W(STEP_W), .NUM_REG(NUM_REG)) u_regmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_step(cur_step),
        .step_map(reg_step_map),
        .auto_en (reg_auto),
        .en      (reg_en)
    );

    // R5
    // active_gate_chk: ACTIVE never shows without both enables
    active_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> sys_on && pwr_on);
endmodule

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;
    localparam int SW = 5;
    localparam int NR = 8;
    localparam int DW = 4;
    localparam int DWELL = 2;
    localparam int SETTLE = 32 * (DWELL + 1) + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_en_pin = 0, pwr_en_pin = 0, pwr_en_reg = 0, ph3_en_reg = 0;
    logic standby_req = 0, wdog_expire = 0, cfg_sys_preset = 0, cfg_pwr_preset = 0;
    logic [SW-1:0] sys_end_ptr = 4, pwr_end_ptr = 8, max_ptr = 12, part_down_ptr = 2;
    logic [DW-1:0] dwell_cycles = DWELL;
    logic [NR*SW-1:0] reg_step_map;
    logic [NR-1:0] reg_auto = 8'b1110_1111;
    logic [SW-1:0] cur_step;
    logic [NR-1:0] reg_en;
    logic [1:0] walk_dir;
    logic active;

    int total = 0;
    int bad = 0;
    int slots [NR] = '{0, 1, 2, 3, 5, 5, 9, 12};

    always #10 clk = ~clk;

    always_comb
        for (int i = 0; i < NR; i++) reg_step_map[i*SW +: SW] = SW'(slots[i]);

    pwr_seq_top #(.STEP_W(SW), .NUM_REG(NR), .DWELL_W(DW)) u_pwr_seq_top (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_goal(bit sys, bit pwr, bit ph3, bit stb, bit lock);
        int t1, m2, t2, t3, pd;
        t1 = (sys_end_ptr < max_ptr) ? sys_end_ptr : max_ptr;
        m2 = (pwr_end_ptr < max_ptr) ? pwr_end_ptr : max_ptr;
        t2 = (m2 > t1) ? m2 : t1;
        t3 = (max_ptr > t2) ? max_ptr : t2;
        pd = (part_down_ptr < sys_end_ptr) ? part_down_ptr : 0;
        if (lock) return 0;
        if (stb) return pd;
        if (!sys) return 0;
        if (!pwr) return t1;
        if (!ph3) return t2;
        return t3;
    endfunction

    function automatic int exp_t2();
        int t1, m2;
        t1 = (sys_end_ptr < max_ptr) ? sys_end_ptr : max_ptr;
        m2 = (pwr_end_ptr < max_ptr) ? pwr_end_ptr : max_ptr;
        return (m2 > t1) ? m2 : t1;
    endfunction

    function automatic logic [NR-1:0] exp_en(int step);
        logic [NR-1:0] v;
        for (int i = 0; i < NR; i++) v[i] = reg_auto[i] && slots[i] != 0 && slots[i] <= step;
        return v;
    endfunction

    task automatic settle_check(bit sys, bit pwr, bit ph3, bit stb, string tag);
        int g;
        repeat (SETTLE) @(negedge clk);
        g = exp_goal(sys, pwr, ph3, stb, 1'b0);
        chk(cur_step == g, tag, cur_step, g);
        chk(reg_en == exp_en(g), "R10", reg_en, exp_en(g));
        chk(walk_dir == 2'b00, "R11", walk_dir, 0);
        chk(active == (sys && pwr && !stb && g >= exp_t2()), "R5", active, 0);
    endtask

    task automatic set_en(bit sys, bit pwr, bit ph3, bit stb);
        sys_en_pin = sys; pwr_en_pin = pwr; ph3_en_reg = ph3; standby_req = stb;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cur_step == 0, "R1", cur_step, 0);
        chk(reg_en == 0, "R1", reg_en, 0);
        chk(walk_dir == 2'b00, "R1", walk_dir, 0);
        chk(active == 0, "R1", active, 0);

        // R9 pacing and R11 direction while climbing (goal 4)
        set_en(1, 0, 0, 0);
        @(negedge clk);
        chk(walk_dir == 2'b01, "R11", walk_dir, 1);
        for (int k = 0; k < 4; k++) begin
            prev = cur_step;
            n = (k == 0) ? 1 : 0;
            while (cur_step == prev && n < 50) begin @(negedge clk); n++; end
            chk(n == DWELL + 1, "R9", n, DWELL + 1);
            chk(cur_step == prev + 1, "R9", cur_step, prev + 1);
        end
        settle_check(1, 0, 0, 0, "R2");

        // R6 descent direction
        set_en(0, 0, 0, 0);
        @(negedge clk);
        chk(walk_dir == 2'b10, "R11", walk_dir, 2);
        settle_check(0, 0, 0, 0, "R6");

        // Sweep: three pointer sets, all enable combinations
        for (int cfg = 0; cfg < 3; cfg++) begin
            case (cfg)
                0: begin sys_end_ptr = 4; pwr_end_ptr = 8;  max_ptr = 12; part_down_ptr = 2; end
                1: begin sys_end_ptr = 6; pwr_end_ptr = 10; max_ptr = 5;  part_down_ptr = 7; end
                default: begin sys_end_ptr = 3; pwr_end_ptr = 9; max_ptr = 31; part_down_ptr = 1; end
            endcase
            for (int c = 0; c < 16; c++) begin
                int cc;
                cc = (c * 7) % 16;
                set_en(cc[0], cc[1], cc[2], cc[3]);
                settle_check(cc[0], cc[1], cc[2], cc[3],
                    cc[3] ? "R7" : !cc[0] ? "R2" : !cc[1] ? "R6" : !cc[2] ? "R3" : "R4");
            end
        end

        // R6 power drop from phase 3 stops at system end; config 0
        sys_end_ptr = 4; pwr_end_ptr = 8; max_ptr = 12; part_down_ptr = 2;
        set_en(1, 1, 1, 0);
        settle_check(1, 1, 1, 0, "R4");
        set_en(1, 0, 1, 0);
        settle_check(1, 0, 1, 0, "R6");

        // R3 register bit and presets as enable sources
        set_en(0, 0, 0, 0); cfg_sys_preset = 1; pwr_en_reg = 1;
        settle_check(1, 1, 0, 0, "R3");
        pwr_en_reg = 0; cfg_pwr_preset = 1;
        settle_check(1, 1, 0, 0, "R3");
        cfg_pwr_preset = 0; cfg_sys_preset = 0;
        settle_check(0, 0, 0, 0, "R2");

        // R7 standby then resume climbs from partial-down step
        set_en(1, 1, 0, 0);
        settle_check(1, 1, 0, 0, "R3");
        standby_req = 1;
        settle_check(1, 1, 0, 1, "R7");
        standby_req = 0;
        n = 0;
        while (cur_step == 2 && n < 50) begin @(negedge clk); n++; end
        chk(cur_step == 3, "R7", cur_step, 3);

        // R8 watchdog snap and lock
        settle_check(1, 1, 0, 0, "R3");
        wdog_expire = 1;
        @(negedge clk);
        wdog_expire = 0;
        chk(cur_step == 0, "R8", cur_step, 0);
        chk(reg_en == 0, "R8", reg_en, 0);
        repeat (SETTLE) @(negedge clk);
        chk(cur_step == 0, "R8", cur_step, 0);
        chk(walk_dir == 2'b00, "R11", walk_dir, 0);
        sys_en_pin = 0;
        @(negedge clk);
        sys_en_pin = 1;
        settle_check(1, 1, 0, 0, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule